// File: doc/BRIEF.md
# Serial Decimal-to-Binary Converter

This block turns a packed string of 4-bit decimal digits into an unsigned binary word. It produces one result bit per clock. On every step it shifts the whole digit string right by one bit position, which halves its decimal value. The bit that drops out of the lowest digit enters the result register at its top end. Any digit that has just received a bit from the digit above it is corrected in the same step.

A client asserts a start strobe together with the digit string. The block captures the digits and runs for a fixed number of steps. It then raises a one-cycle done strobe and keeps the binary value on its output until the next conversion finishes. The digit count and the result width are parameters. The default setting converts five digits into a 16-bit word. The client must supply valid digits whose value fits in the result width.

Top module: `bcd_to_bin_serial`

## Requirements
- R1: While reset is active and in the first cycle after it is released, `done_o` is 0 and `bin_o` is 0.
- R2: A start seen while the block is idle captures `bcd_i`. Changes on `bcd_i` after that capture edge do not affect the result.
- R3: `done_o` goes high exactly BIN_W clock edges after the capture edge and stays high for exactly one cycle.
- R4: Digit i sits in `bcd_i[4*i+3:4*i]`, and digit 0 is the least significant. For every string of valid digits (each 0..9) whose value is below 2^BIN_W, `bin_o` equals that value once `done_o` is high.
- R5: A start that arrives while a conversion is running is ignored. The running conversion keeps its timing and its result, and no extra done pulse appears.
- R6: `bin_o` changes only on the edge that raises `done_o`. Between conversions it keeps its value, whatever `bcd_i` and `start_i` do.
- R7: On every step, a digit whose shifted value is 8 or more has 3 subtracted from it, so every digit stays within 0..9 for the whole conversion.
- R8: A start presented in the same cycle that `done_o` is high is accepted, so conversions can run back to back every BIN_W+1 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts a conversion when the block is idle |
| bcd_i | input | 4*NUM_DIGITS | Packed decimal digits, digit 0 in the low nibble |
| done_o | output | 1 | One-cycle pulse when the result is valid |
| bin_o | output | BIN_W | Registered binary result |

## Verification
On every cycle the assertions check the following:
- the done pulse is one cycle wide;
- the done pulse comes exactly BIN_W edges after the capture edge, measured with a checker counter;
- a running conversion advances without being reloaded;
- the result register changes only together with done;
- every working digit stays a legal decimal value during the shifts.

The bench scenarios show the things a property cannot state on its own. These are the arithmetic result for a wide spread of values, including the decade boundaries and the largest value. They also include the isolation of the captured digits from later input changes and the acceptance of a start in the done cycle.

// File: rtl/bcd2bin_pkg.sv
package bcd2bin_pkg;

  localparam int unsigned DIGIT_W = 4;

  // One right-shift step of a single decimal digit: the bit from the digit
  // above lands in weight 8 but is worth 5 here, so 3 is taken back.
  function automatic logic [DIGIT_W-1:0] digit_step(input logic [DIGIT_W-1:0] cur,
                                                    input logic             hi_bit);
    logic [DIGIT_W-1:0] raw;
    raw = {hi_bit, cur[DIGIT_W-1:1]};
    if (raw >= 4'd8) return raw - 4'd3;
    return raw;
  endfunction

  function automatic logic digit_needs_fix(input logic [DIGIT_W-1:0] cur,
                                           input logic             hi_bit);
    logic [DIGIT_W-1:0] raw;
    raw = {hi_bit, cur[DIGIT_W-1:1]};
    return (raw >= 4'd8);
  endfunction

endpackage

// File: rtl/bcd_digit_cell.sv
module bcd_digit_cell
  import bcd2bin_pkg::*;
(
  input  logic [DIGIT_W-1:0] cur_i,
  input  logic               hi_bit_i,
  output logic [DIGIT_W-1:0] nxt_o,
  output logic               lo_bit_o,
  output logic               fix_o
);

  always_comb begin
    nxt_o    = digit_step(cur_i, hi_bit_i);
    fix_o    = digit_needs_fix(cur_i, hi_bit_i);
    lo_bit_o = cur_i[0];
  end

endmodule

// File: rtl/bcd_shift_chain.sv
module bcd_shift_chain
  import bcd2bin_pkg::*;
#(
  parameter int unsigned NUM_DIGITS = 5,
  localparam int unsigned STR_W = NUM_DIGITS * DIGIT_W
) (
  input  logic [STR_W-1:0]      str_q_i,
  output logic [STR_W-1:0]      str_next_o,
  output logic                  shift_out_o,
  output logic [NUM_DIGITS-1:0] fix_vec_o
);

  logic [NUM_DIGITS-1:0] lo_bits;

  for (genvar gi = 0; gi < NUM_DIGITS; gi++) begin : g_cell
    logic hi_bit;
    if (gi == NUM_DIGITS - 1) begin : g_top
      assign hi_bit = 1'b0;
    end else begin : g_mid
      assign hi_bit = lo_bits[gi+1];
    end

    bcd_digit_cell u_cell (
      .cur_i   (str_q_i[gi*DIGIT_W +: DIGIT_W]),
      .hi_bit_i(hi_bit),
      .nxt_o   (str_next_o[gi*DIGIT_W +: DIGIT_W]),
      .lo_bit_o(lo_bits[gi]),
      .fix_o   (fix_vec_o[gi])
    );
  end

  assign shift_out_o = lo_bits[0];

endmodule

// File: rtl/bin_collect.sv
module bin_collect #(
  parameter int unsigned BIN_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             shift_i,
  input  logic             bit_i,
  output logic [BIN_W-1:0] acc_o,
  output logic [BIN_W-1:0] acc_next_o
);

  assign acc_next_o = {bit_i, acc_o[BIN_W-1:1]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      acc_o <= '0;
    else if (clear_i) acc_o <= '0;
    else if (shift_i) acc_o <= acc_next_o;
  end

endmodule

// File: rtl/step_ctrl.sv
module step_ctrl #(
  parameter int unsigned BIN_W = 16,
  localparam int unsigned CNT_W = $clog2(BIN_W + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic load_o,
  output logic step_o,
  output logic last_o,
  output logic done_o
);

  localparam logic [CNT_W-1:0] STEPS = CNT_W'(BIN_W);

  logic [CNT_W-1:0] left_q;

  assign load_o = start_i && !busy_o;
  assign step_o = busy_o;
  assign last_o = busy_o && (left_q == CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      left_q <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= last_o;
      if (load_o) begin
        busy_o <= 1'b1;
        left_q <= STEPS;
      end else if (step_o) begin
        left_q <= left_q - CNT_W'(1);
        if (last_o) busy_o <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/bcd_to_bin_serial.sv
module bcd_to_bin_serial
  import bcd2bin_pkg::*;
#(
  parameter int unsigned NUM_DIGITS = 5,
  parameter int unsigned BIN_W      = 16,
  localparam int unsigned STR_W     = NUM_DIGITS * DIGIT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [STR_W-1:0] bcd_i,
  output logic             done_o,
  output logic [BIN_W-1:0] bin_o
);

  // Named internal events, also observed by the bound checker.
  logic                  busy;
  logic                  start_taken;
  logic                  step_fire;
  logic                  last_step;
  logic [STR_W-1:0]      str_q;
  logic [STR_W-1:0]      str_next;
  logic                  shift_bit;
  logic [NUM_DIGITS-1:0] fix_vec;
  logic [BIN_W-1:0]      acc_q;
  logic [BIN_W-1:0]      acc_next;

  step_ctrl #(.BIN_W(BIN_W)) u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .busy_o (busy),
    .load_o (start_taken),
    .step_o (step_fire),
    .last_o (last_step),
    .done_o (done_o)
  );

  bcd_shift_chain #(.NUM_DIGITS(NUM_DIGITS)) u_chain (
    .str_q_i    (str_q),
    .str_next_o (str_next),
    .shift_out_o(shift_bit),
    .fix_vec_o  (fix_vec)
  );

  bin_collect #(.BIN_W(BIN_W)) u_acc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (start_taken),
    .shift_i   (step_fire),
    .bit_i     (shift_bit),
    .acc_o     (acc_q),
    .acc_next_o(acc_next)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          str_q <= '0;
    else if (start_taken) str_q <= bcd_i;
    else if (step_fire)   str_q <= str_next;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        bin_o <= '0;
    else if (last_step) bin_o <= acc_next;
  end

endmodule

// File: rtl/bcd_to_bin_serial_chk.sv
module bcd_to_bin_serial_chk #(
  parameter int unsigned NUM_DIGITS = 5,
  parameter int unsigned BIN_W      = 16
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    done_o,
  input logic [BIN_W-1:0]        bin_o,
  input logic                    busy,
  input logic                    start_taken,
  input logic                    last_step,
  input logic [NUM_DIGITS*4-1:0] str_q
);

  localparam int unsigned LAT_W = $clog2(BIN_W + 1) + 1;

  logic [LAT_W-1:0] lat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          lat_q <= '0;
    else if (start_taken) lat_q <= '0;
    else if (busy)        lat_q <= lat_q + LAT_W'(1);
  end

  assert_done_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_latency_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (lat_q == LAT_W'(BIN_W)));

  assert_no_reload_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && !last_step) |=> (busy && lat_q == $past(lat_q) + LAT_W'(1)));

  assert_result_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(bin_o) |-> done_o);

  assert_idle_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy && !$past(busy)) |-> !done_o);

  for (genvar gd = 0; gd < NUM_DIGITS; gd++) begin : g_dig
    assert_digit_legal_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      busy |-> (str_q[gd*4 +: 4] <= 4'd9));
  end

endmodule

bind bcd_to_bin_serial bcd_to_bin_serial_chk #(
  .NUM_DIGITS(NUM_DIGITS),
  .BIN_W     (BIN_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .done_o     (done_o),
  .bin_o      (bin_o),
  .busy       (busy),
  .start_taken(start_taken),
  .last_step  (last_step),
  .str_q      (str_q)
);

// File: tb/bcd_to_bin_serial_bench.sv
`timescale 1ns/1ps
module bcd_to_bin_serial_bench;

  localparam int ND    = 5;
  localparam int BW    = 16;
  localparam int SW    = ND * 4;
  localparam int LIMIT = 60;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [SW-1:0] bcd = '0;
  logic          done;
  logic [BW-1:0] bin;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  bcd_to_bin_serial #(.NUM_DIGITS(ND), .BIN_W(BW)) u_bcd_to_bin_serial (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .start_i(start),
    .bcd_i  (bcd),
    .done_o (done),
    .bin_o  (bin)
  );

  function automatic logic [SW-1:0] to_bcd(input int value);
    logic [SW-1:0] r;
    int v;
    v = value;
    r = '0;
    for (int i = 0; i < ND; i++) begin
      r[i*4 +: 4] = 4'(v % 10);
      v = v / 10;
    end
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Waits from the negedge after the capture edge until done is seen.
  task automatic wait_done(output int lat);
    lat = 0;
    while (!done && lat < LIMIT) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic convert(input int value, input string req);
    int lat;
    @(negedge clk);
    start = 1'b1;
    bcd   = to_bcd(value);
    @(negedge clk);
    start = 1'b0;
    wait_done(lat);
    check(lat == BW, {req, " latency"}, lat, BW);
    check(int'(bin) == value, {req, " value"}, int'(bin), value);
  endtask

  task automatic t_reset_R1();
    check(done == 1'b0, "R1 done in reset", done, 0);
    check(bin == '0, "R1 bin in reset", int'(bin), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(done == 1'b0, "R1 done after reset", done, 0);
    check(bin == '0, "R1 bin after reset", int'(bin), 0);
  endtask

  task automatic t_sweep_R4();
    for (int v = 0; v < 200; v++) convert(v, "R4 low range");
    for (int v = 200; v < 65536; v += 37) convert(v, "R4 stride");
    convert(9, "R4 boundary 9");
    convert(10, "R4 boundary 10");
    convert(99, "R4 boundary 99");
    convert(1000, "R4 boundary 1000");
    convert(9999, "R4 boundary 9999");
    convert(10000, "R4 boundary 10000");
    convert(59999, "R7 many fixes");
    convert(65534, "R4 boundary 65534");
    convert(65535, "R4 max");
  endtask

  task automatic t_capture_R2();
    int lat;
    @(negedge clk);
    start = 1'b1;
    bcd   = to_bcd(4321);
    @(negedge clk);
    start = 1'b0;
    bcd   = to_bcd(8765);
    wait_done(lat);
    check(int'(bin) == 4321, "R2 captured value", int'(bin), 4321);
  endtask

  task automatic t_ignore_R5();
    int lat;
    int extra;
    @(negedge clk);
    start = 1'b1;
    bcd   = to_bcd(31415);
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    for (int i = 0; i < 5; i++) begin @(negedge clk); lat++; end
    start = 1'b1;
    bcd   = to_bcd(27182);
    for (int i = 0; i < 3; i++) begin @(negedge clk); lat++; end
    start = 1'b0;
    while (!done && lat < LIMIT) begin @(negedge clk); lat++; end
    check(lat == BW, "R5 latency kept", lat, BW);
    check(int'(bin) == 31415, "R5 result kept", int'(bin), 31415);
    extra = 0;
    for (int i = 0; i < 2 * BW; i++) begin @(negedge clk); if (done) extra++; end
    check(extra == 0, "R5 no extra done", extra, 0);
  endtask

  task automatic t_hold_R6();
    int seen;
    logic [BW-1:0] held;
    convert(12345, "R6 setup");
    held = bin;
    bcd  = to_bcd(54321);
    seen = 0;
    for (int i = 0; i < 2 * BW; i++) begin
      @(negedge clk);
      if (done || bin != held) seen++;
    end
    check(seen == 0, "R6 hold changes", seen, 0);
    check(bin == held, "R6 hold value", int'(bin), int'(held));
  endtask

  task automatic t_back_to_back_R8();
    int lat;
    @(negedge clk);
    start = 1'b1;
    bcd   = to_bcd(777);
    @(negedge clk);
    start = 1'b0;
    wait_done(lat);
    check(int'(bin) == 777, "R8 first value", int'(bin), 777);
    start = 1'b1;
    bcd   = to_bcd(60001);
    @(negedge clk);
    start = 1'b0;
    wait_done(lat);
    check(lat == BW, "R8 second latency", lat, BW);
    check(int'(bin) == 60001, "R8 second value", int'(bin), 60001);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    @(negedge clk);
    t_reset_R1();
    t_capture_R2();
    t_ignore_R5();
    t_hold_R6();
    t_back_to_back_R8();
    t_sweep_R4();
    repeat (4) @(negedge clk);
    finish_run();
  end

endmodule